// File: doc/BRIEF.md
# Masked Dual Alarm Comparator

This block compares a running calendar time with two programmable alarms and keeps one sticky flag for each. The first alarm can compare second, minute, hour, date, month and day-of-week. The second alarm can compare minute and hour, plus one more byte that compares either the date or the day-of-week. Bit 7 of every alarm byte enables that field. A field whose enable is 0 is left out of the match. When all fields are disabled, the first alarm fires on every second and the second alarm fires on every minute.

The time keeper drives the time fields and pulses `tick_i` in the cycle in which those fields hold the newly advanced second. A host writes alarm bytes and control bits through a small byte-wide write port. It signals the end of a status-register read on `rd_done_i`. A flag is set by a match. Software can clear it only by writing 0 to its bit. It is also cleared by a finished read when the auto-clear bit is 1.

Top module: `alarm_match_unit`

## Requirements
- R1: After `rst_ni` is asserted, both flags, both master enables, the auto-clear bit and every alarm byte are 0.
- R2: A write is accepted when `wr_i` is 1 and takes effect from the next cycle. The address map is: 0 status (bit 7 auto-clear, bit 2 alarm-1 flag, bit 1 alarm-2 flag), 1 control (bit 6 alarm-1 master enable, bit 5 alarm-2 master enable), 2..7 alarm-1 bytes for second, minute, hour, date, month and day-of-week, and 8..10 alarm-2 bytes for minute, hour and day. Writes to other addresses have no effect.
- R3: Alarm 1 is checked when `tick_i` is 1 and its master enable is 1. It matches when every enabled byte has bits [6:0] equal to the matching time input. On a match, `a1_flag_o` is 1 from the next cycle.
- R4: When all six alarm-1 field enables are 0 and its master enable is 1, every tick sets `a1_flag_o`.
- R5: Alarm 2 can match only on a tick where `sec_i` is 0. With all its field enables at 0 it fires on every such tick.
- R6: Alarm-2 day byte: bit 6 = 1 compares bits [5:0] with `wday_i[5:0]`, and bit 6 = 0 compares them with `date_i[5:0]`.
- R7: `hour_i[6]` is the 24-hour format bit and bit 6 of an alarm hour byte is its format bit. An enabled hour byte whose format bit differs from the running format never matches.
- R8: A flag is never set in a cycle without `tick_i`.
- R9: A write to address 0 clears a flag whose bit in the data is 0. A 1 in that bit leaves the flag unchanged and never sets it.
- R10: A pulse on `rd_done_i` clears both flags when auto-clear is 1. It has no effect when auto-clear is 0.
- R11: A match in the same cycle as a clearing write or auto-clear leaves the flag set.
- R12: An alarm whose master enable is 0 never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time fields hold a newly advanced second |
| sec_i | input | 7 | Running seconds, BCD |
| min_i | input | 7 | Running minutes, BCD |
| hour_i | input | 7 | Bit 6 is the 24-hour format bit; [5:0] is the hour value |
| date_i | input | 7 | Running date, BCD |
| month_i | input | 7 | Running month, BCD |
| wday_i | input | 7 | Running day-of-week |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rd_done_i | input | 1 | Status-register read completed |
| a1_flag_o | output | 1 | Alarm-1 sticky flag |
| a2_flag_o | output | 1 | Alarm-2 sticky flag |

## Verification
A match and a clear can fall in the same cycle. The clear can be a status write with a 0 in the flag bit, or a finished read while auto-clear is on. The bench makes this happen on purpose by issuing a tick that matches together with each kind of clear. It expects the flag to read 1 afterwards. Random traffic mixes ticks, writes and read pulses freely, so these collisions also occur at random, and a bench model that gives the set priority judges each one.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int unsigned AW       = 4;
  localparam int unsigned N_A1     = 6;
  localparam int unsigned N_A2     = 3;
  localparam int unsigned TW       = 7;
  localparam logic [AW-1:0] ADDR_STAT = 4'd0;
  localparam logic [AW-1:0] ADDR_CTRL = 4'd1;
  localparam logic [AW-1:0] ADDR_A1   = 4'd2;
  localparam logic [AW-1:0] ADDR_A2   = ADDR_A1 + AW'(N_A1);
  localparam int unsigned STAT_AUTO = 7;
  localparam int unsigned STAT_F1   = 2;
  localparam int unsigned STAT_F2   = 1;
  localparam int unsigned CTRL_E1   = 6;
  localparam int unsigned CTRL_E2   = 5;
  localparam int unsigned FLD_EN    = 7;

  typedef logic [7:0]    abyte_t;
  typedef logic [TW-1:0] tfield_t;

  // disabled field always agrees; hour format bit sits in bit 6 of both sides
  function automatic logic field_hit(abyte_t a, tfield_t t);
    return !a[FLD_EN] || (a[6:0] == t);
  endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [7:0]                wdata_i,
  output logic [N_A1-1:0][7:0]      a1_o,
  output logic [N_A2-1:0][7:0]      a2_o,
  output logic                      a1_en_o,
  output logic                      a2_en_o,
  output logic                      auto_o,
  output logic                      clr1_o,
  output logic                      clr2_o
);
  logic [N_A1-1:0][7:0] a1_q;
  logic [N_A2-1:0][7:0] a2_q;
  logic e1_q, e2_q, auto_q;
  logic wr_stat;

  assign wr_stat = wr_i && (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1_q   <= '0;
      a2_q   <= '0;
      e1_q   <= 1'b0;
      e2_q   <= 1'b0;
      auto_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == ADDR_STAT) auto_q <= wdata_i[STAT_AUTO];
      if (addr_i == ADDR_CTRL) begin
        e1_q <= wdata_i[CTRL_E1];
        e2_q <= wdata_i[CTRL_E2];
      end
      for (int i = 0; i < N_A1; i++)
        if (addr_i == ADDR_A1 + AW'(i)) a1_q[i] <= wdata_i;
      for (int i = 0; i < N_A2; i++)
        if (addr_i == ADDR_A2 + AW'(i)) a2_q[i] <= wdata_i;
    end
  end

  assign a1_o    = a1_q;
  assign a2_o    = a2_q;
  assign a1_en_o = e1_q;
  assign a2_en_o = e2_q;
  assign auto_o  = auto_q;
  assign clr1_o  = wr_stat && !wdata_i[STAT_F1];
  assign clr2_o  = wr_stat && !wdata_i[STAT_F2];
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0][7:0]    abyte_i,
  input  logic [N-1:0][TW-1:0] tfield_i,
  input  logic                 en_i,
  input  logic                 tick_i,
  input  logic                 qual_i,
  output logic                 hit_o
);
  logic [N-1:0] fld_ok;

  for (genvar g = 0; g < N; g++) begin : g_fld
    assign fld_ok[g] = field_hit(abyte_i[g], tfield_i[g]);
  end

  assign hit_o = en_i && tick_i && qual_i && (&fld_ok);
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;   // set outranks any clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r3_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  a_r11_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> flag_q);
  a_r9_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
  a_r8_no_set_without_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !set_i) |=> !flag_q);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [TW-1:0] sec_i,
  input  logic [TW-1:0] min_i,
  input  logic [TW-1:0] hour_i,
  input  logic [TW-1:0] date_i,
  input  logic [TW-1:0] month_i,
  input  logic [TW-1:0] wday_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          rd_done_i,
  output logic          a1_flag_o,
  output logic          a2_flag_o
);
  logic [N_A1-1:0][7:0]   a1_b;
  logic [N_A2-1:0][7:0]   a2_b;
  logic [N_A1-1:0][TW-1:0] a1_t;
  logic [N_A2-1:0][TW-1:0] a2_t;
  logic [N_A2-1:0][7:0]   a2_b_m;
  logic a1_en, a2_en, auto_clr, wclr1, wclr2;
  logic [1:0] hit, clr, flag;

  alm_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .a1_o(a1_b), .a2_o(a2_b), .a1_en_o(a1_en), .a2_en_o(a2_en),
    .auto_o(auto_clr), .clr1_o(wclr1), .clr2_o(wclr2)
  );

  assign a1_t = {wday_i, month_i, date_i, hour_i, min_i, sec_i};

  // day byte: bit 6 selects day-of-week vs date, compare on [5:0]
  assign a2_t[0]   = min_i;
  assign a2_t[1]   = hour_i;
  assign a2_t[2]   = {1'b0, a2_b[2][6] ? wday_i[5:0] : date_i[5:0]};
  assign a2_b_m[0] = a2_b[0];
  assign a2_b_m[1] = a2_b[1];
  assign a2_b_m[2] = {a2_b[2][7], 1'b0, a2_b[2][5:0]};

  alm_match #(.N(N_A1)) u_m1 (
    .abyte_i(a1_b), .tfield_i(a1_t), .en_i(a1_en), .tick_i,
    .qual_i(1'b1), .hit_o(hit[0])
  );
  alm_match #(.N(N_A2)) u_m2 (
    .abyte_i(a2_b_m), .tfield_i(a2_t), .en_i(a2_en), .tick_i,
    .qual_i(sec_i == '0), .hit_o(hit[1])
  );

  assign clr[0] = wclr1 || (rd_done_i && auto_clr);
  assign clr[1] = wclr2 || (rd_done_i && auto_clr);

  for (genvar g = 0; g < 2; g++) begin : g_flag
    alm_flag u_flag (.clk_i, .rst_ni, .set_i(hit[g]), .clr_i(clr[g]), .flag_o(flag[g]));
  end

  assign a1_flag_o = flag[0];
  assign a2_flag_o = flag[1];

  a_r12_master_gate1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a1_en && !a1_flag_o) |=> !a1_flag_o);
  a_r12_master_gate2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a2_en && !a2_flag_o) |=> !a2_flag_o);
  a_r5_minute_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a2_flag_o && !(tick_i && sec_i == '0)) |=> !a2_flag_o);
  a_r10_auto_off_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a1_flag_o && rd_done_i && !auto_clr && !wclr1) |=> a1_flag_o);
endmodule

// File: tb/sim_alarm_match_unit.sv
module sim_alarm_match_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, wr = 0, rd = 0;
  logic [6:0] sec = 0, mn = 0, hr = 0, dt = 0, mo = 0, wd = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic f1, f2;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_a1 [6];
  logic [7:0] m_a2 [3];
  logic m_e1 = 0, m_e2 = 0, m_auto = 0, e1 = 0, e2 = 0;

  always #5 clk = ~clk;

  alarm_match_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .sec_i(sec), .min_i(mn), .hour_i(hr), .date_i(dt), .month_i(mo), .wday_i(wd),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rd_done_i(rd),
    .a1_flag_o(f1), .a2_flag_o(f2)
  );

  function automatic bit fh(logic [7:0] a, logic [6:0] t);
    return (a[7] == 1'b0) || (a[6:0] == t);
  endfunction

  function automatic bit day_hit(logic [7:0] a, logic [6:0] d, logic [6:0] w);
    if (!a[7]) return 1'b1;
    return a[6] ? (a[5:0] == w[5:0]) : (a[5:0] == d[5:0]);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit h1, h2, c1, c2;
    h1 = tick && m_e1 && fh(m_a1[0], sec) && fh(m_a1[1], mn) && fh(m_a1[2], hr)
         && fh(m_a1[3], dt) && fh(m_a1[4], mo) && fh(m_a1[5], wd);
    h2 = tick && m_e2 && (sec == 0) && fh(m_a2[0], mn) && fh(m_a2[1], hr)
         && day_hit(m_a2[2], dt, wd);
    c1 = (wr && addr == 0 && !wdata[2]) || (rd && m_auto);
    c2 = (wr && addr == 0 && !wdata[1]) || (rd && m_auto);
    e1 = h1 | (e1 & ~c1);
    e2 = h2 | (e2 & ~c2);
    if (wr) begin
      if (addr == 0) m_auto = wdata[7];
      if (addr == 1) begin m_e1 = wdata[6]; m_e2 = wdata[5]; end
      if (addr >= 2 && addr <= 7) m_a1[addr-2] = wdata;
      if (addr >= 8 && addr <= 10) m_a2[addr-8] = wdata;
    end
    @(posedge clk);
    #2;
    chk({tag, " a1"}, f1, e1);
    chk({tag, " a2"}, f2, e2);
    @(negedge clk);
    tick = 0; wr = 0; rd = 0;
  endtask

  task automatic wreg(logic [3:0] a, logic [7:0] d, string tag);
    wr = 1; addr = a; wdata = d; step(tag);
  endtask

  task automatic settime(logic [6:0] s, logic [6:0] m, logic [6:0] h,
                         logic [6:0] d, logic [6:0] mo_v, logic [6:0] w);
    sec = s; mn = m; hr = h; dt = d; mo = mo_v; wd = w;
  endtask

  function automatic logic [6:0] pick(logic [6:0] a, logic [6:0] b);
    return ($urandom % 2) ? a : b;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) m_a1[i] = 0;
    for (int i = 0; i < 3; i++) m_a2[i] = 0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 reset a1", f1, 1'b0);
    chk("R1 reset a2", f2, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // R12: defaults leave masters off, all-disabled alarms do nothing
    settime(0, 7'h30, 7'h11, 1, 1, 1);
    tick = 1; step("R12 R1 master default off");
    // R4: master 1 on, all fields disabled -> every second
    wreg(1, 8'h40, "R2 ctrl write");
    settime(7'h17, 7'h30, 7'h11, 1, 1, 1);
    tick = 1; step("R4 every second");
    // R9: writing ones keeps, zero clears
    wreg(0, 8'h06, "R9 write one keeps");
    wreg(0, 8'h00, "R9 write zero clears");
    // R8: no tick no set
    step("R8 no tick");
    // R10: auto-clear off
    tick = 1; step("R4 set again");
    rd = 1; step("R10 read auto off");
    wreg(0, 8'h84, "R10 enable auto");
    rd = 1; step("R10 read auto on");
    // R11: set with clear
    tick = 1; rd = 1; step("R11 match vs auto-clear");
    tick = 1; wr = 1; addr = 0; wdata = 8'h80; step("R11 match vs write clear");
    wreg(0, 8'h00, "R9 clear all");
    // R7: hour format
    wreg(4, 8'h91, "R2 a1 hour 12h 11");
    settime(7'h05, 7'h30, 7'h51, 1, 1, 1);
    tick = 1; step("R7 format mismatch");
    settime(7'h05, 7'h30, 7'h11, 1, 1, 1);
    tick = 1; step("R3 hour match");
    wreg(0, 8'h00, "R9 clear");
    wreg(3, 8'hB1, "R2 a1 min 31");
    tick = 1; step("R3 minute mismatch");
    wreg(15, 8'hFF, "R2 unmapped write");
    tick = 1; step("R2 unmapped no effect");
    // R5 / R6
    wreg(1, 8'h20, "R2 ctrl a2 only");
    settime(7'h01, 7'h30, 7'h11, 1, 1, 2);
    tick = 1; step("R5 sec nonzero");
    settime(7'h00, 7'h30, 7'h11, 1, 1, 2);
    tick = 1; step("R5 every minute");
    wreg(0, 8'h00, "R9 clear");
    wreg(10, 8'hC1, "R6 a2 day sel wday 1");
    tick = 1; step("R6 wday mismatch");
    settime(7'h00, 7'h30, 7'h11, 2, 1, 1);
    tick = 1; step("R6 wday match");
    wreg(0, 8'h00, "R9 clear");
    wreg(10, 8'h81, "R6 a2 day sel date 1");
    tick = 1; step("R6 date mismatch");
    settime(7'h00, 7'h30, 7'h11, 1, 1, 2);
    tick = 1; step("R6 date match");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom % 10;
      settime(pick(0, 1), pick(7'h30, 7'h31), {1'($urandom), pick(7'h11, 7'h12) & 7'h3F},
              pick(1, 2), pick(1, 2), pick(1, 2));
      tick = ($urandom % 3) != 0;
      rd = (op == 0);
      if (op >= 6) begin
        logic [3:0] a;
        logic [7:0] d;
        a = 4'($urandom % 12);
        d = 8'($urandom);
        if (a >= 2 && a <= 10) begin
          d[5:0] = pick(1, 2) [5:0];
          if (a == 3 || a == 8) d[6:0] = pick(7'h30, 7'h31);
          if (a == 4 || a == 9) d[6:0] = {1'($urandom), pick(7'h11, 7'h12) & 7'h3F};
          if (a == 2) d[6:0] = pick(0, 1);
          if (a != 10 && a != 3 && a != 8 && a != 4 && a != 9) d[6] = 1'b0;
          if ($urandom % 3 == 0) d[7] = 1'b0;
        end
        wr = 1; addr = a; wdata = d;
      end
      step("R3 R5 R9 R10 R11 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule